// File: doc/BRIEF.md
# Virtually Tagged Word Filter Cache

This block is a small, fully associative store of recently touched data words. It is consulted in the execute stage of a five-stage pipeline, before the first-level data cache is started. One lookup port takes a virtual address and answers in the same cycle with a hit flag and a 32-bit word. A hit lets the pipeline skip the larger and costlier first-level access. One write port, driven from the writeback stage, carries every store and every word that a load brought back. This keeps the block write-through and lets it allocate on write.

Tags are virtual line addresses, so a hit needs no address translation. The block must still contain nothing that the physically tagged first-level cache does not hold. For that reason each entry records which first-level way its line lives in. When that cache reports an eviction as a set index and a way, every matching entry is dropped without any physical address. Only the word actually written becomes valid, and the rest of a line is never fetched. If the pipeline flags a lookup address as a wrong speculation, the lookup is turned into a miss.

Top module: `vtag_filter_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every line and word valid flag, so every lookup afterwards misses.
- R2: A lookup hits (`lk_hit`=1 in the same cycle as `lk_valid`) exactly when a valid line holds tag `lk_addr[31:5]` and the valid flag of word `lk_addr[4:2]` in that line is set. On a hit, `lk_data` is that stored word. On a miss, `lk_data` is zero.
- R3: While `lk_spec_bad` is 1, a lookup always misses, whatever the cache holds.
- R4: A write whose tag matches a valid line updates word `wr_addr[4:2]`. Mask bit b selects byte bits [8b+7:8b]. A mask of 4'hF stores the whole word and sets its valid flag. A partial mask merges into a word that is already valid, and leaves an invalid word invalid. The result is visible to lookups from the next cycle on.
- R5: A write whose tag matches no valid line allocates a line with that tag. Only the written word can become valid, and only with mask 4'hF. All other words of the line start invalid, and a lookup miss never allocates.
- R6: An eviction report (`ev_valid`) invalidates, from the next cycle on, every line whose stored way equals `ev_way` and whose tag bits [10:5] (address bits) equal `ev_set`. All other lines are left as they are.
- R7: When an eviction matches a line in the same cycle as a write to that line, the line ends invalid.
- R8: The allocation victim is the lowest-numbered invalid line. If all lines are valid, the victim is the round-robin pointer, or the line after it if the pointer equals the most recently used line. The pointer resets to 0 and moves to the line after the victim after each such replacement. The most recently used line is the line of the latest write, or else of the latest lookup hit. A write takes precedence when both happen in the same cycle.
- R9: Every write records `wr_l1way` in its line, and eviction matching uses the most recently recorded way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request in execute stage |
| lk_addr | input | 32 | Virtual lookup address |
| lk_spec_bad | input | 1 | Speculated address known wrong; force miss |
| lk_hit | output | 1 | Same-cycle hit flag |
| lk_data | output | 32 | Same-cycle hit word, zero on miss |
| wr_valid | input | 1 | Write from writeback stage |
| wr_addr | input | 32 | Virtual write address |
| wr_data | input | 32 | Write word |
| wr_mask | input | 4 | Byte enables |
| wr_l1way | input | 1 | First-level way holding the written line |
| ev_valid | input | 1 | First-level eviction report |
| ev_set | input | 6 | Evicted first-level set index |
| ev_way | input | 1 | Evicted first-level way |

## Verification
The lookup answer is combinational, so the bench drives each lookup just after a falling edge and samples `lk_hit` and `lk_data` one nanosecond later, in that same cycle. Writes and eviction reports take effect at the next rising edge, so their results are always checked by a lookup issued in a later cycle. The bench never issues a lookup in the same cycle as a write. Its reference contents, most-recently-used index and round-robin pointer are updated at the moment each operation is driven. The expected value of each sample is therefore the state after every earlier operation has been committed.

// File: rtl/vfc_pkg.sv
`timescale 1ns/1ps
package vfc_pkg;
  localparam int ADDR_BITS  = 32;
  localparam int WORD_BITS  = 32;
  localparam int WORD_BYTES = WORD_BITS / 8;
  localparam int BOFF_W     = $clog2(WORD_BYTES);

  typedef logic [WORD_BITS-1:0]  word_t;
  typedef logic [WORD_BYTES-1:0] bmask_t;

  // Byte-enable merge of a new word into an old one.
  function automatic word_t merge_bytes(word_t old_w, word_t new_w, bmask_t m);
    word_t r;
    r = old_w;
    for (int b = 0; b < WORD_BYTES; b++)
      if (m[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  // Modulo-n increment for non-power-of-two line counts.
  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/vfc_line.sv
`timescale 1ns/1ps
module vfc_line
  import vfc_pkg::*;
#(
  parameter int TAG_W  = 27,
  parameter int WAY_W  = 1,
  parameter int WORDS  = 8,
  parameter int WSEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        alloc_en,
  input  logic                        hit_wr_en,
  input  logic                        evict_en,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [WSEL_W-1:0]           wr_sel,
  input  word_t                       wr_data,
  input  bmask_t                      wr_mask,
  output logic                        line_ok,
  output logic [TAG_W-1:0]            tag_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [WORDS-1:0]            wvld_o,
  output logic [WORDS-1:0][WORD_BITS-1:0] data_o
);
  logic                            vld_q;
  logic [TAG_W-1:0]                tag_q;
  logic [WAY_W-1:0]                way_q;
  logic [WORDS-1:0]                wv_q;
  logic [WORDS-1:0][WORD_BITS-1:0] data_q;

  logic full_word;
  assign full_word = &wr_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      wv_q  <= '0;
    end else begin
      if (alloc_en) begin
        vld_q          <= 1'b1;
        tag_q          <= wr_tag;
        way_q          <= wr_way;
        wv_q           <= full_word ? (WORDS'(1) << wr_sel) : '0;
        data_q[wr_sel] <= wr_data;
      end else if (hit_wr_en) begin
        way_q <= wr_way;
        if (full_word) begin
          wv_q[wr_sel]   <= 1'b1;
          data_q[wr_sel] <= wr_data;
        end else if (wv_q[wr_sel]) begin
          data_q[wr_sel] <= merge_bytes(data_q[wr_sel], wr_data, wr_mask);
        end
      end
      if (evict_en) vld_q <= 1'b0;  // eviction overrides any same-cycle write
    end
  end

  assign line_ok = vld_q;
  assign tag_o   = tag_q;
  assign way_o   = way_q;
  assign wvld_o  = wv_q;
  assign data_o  = data_q;
endmodule

// File: rtl/vfc_match.sv
`timescale 1ns/1ps
module vfc_match #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 27,
  parameter int WAY_W  = 1,
  parameter int SET_W  = 6,
  parameter int WORDS  = 8,
  parameter int WSEL_W = 3
) (
  input  logic [LINES-1:0]             line_vld,
  input  logic [LINES-1:0][TAG_W-1:0]  tags,
  input  logic [LINES-1:0][WAY_W-1:0]  ways,
  input  logic [LINES-1:0][WORDS-1:0]  wvld,
  input  logic                         lk_en,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [WSEL_W-1:0]            lk_sel,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic                         ev_en,
  input  logic [SET_W-1:0]             ev_set,
  input  logic [WAY_W-1:0]             ev_way,
  output logic [LINES-1:0]             lk_word_hits,
  output logic [LINES-1:0]             wr_tag_hits,
  output logic [LINES-1:0]             ev_hits
);
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    logic lk_tag_eq;
    assign lk_tag_eq       = line_vld[i] && (tags[i] == lk_tag);
    assign lk_word_hits[i] = lk_en && lk_tag_eq && wvld[i][lk_sel];
    assign wr_tag_hits[i]  = line_vld[i] && (tags[i] == wr_tag);
    assign ev_hits[i]      = ev_en && line_vld[i] && (ways[i] == ev_way)
                             && (tags[i][SET_W-1:0] == ev_set);
  end
endmodule

// File: rtl/vfc_victim.sv
`timescale 1ns/1ps
module vfc_victim #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic [LINES-1:0] line_vld,
  input  logic [IDX_W-1:0] mru_idx,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] victim_idx,
  output logic             all_full
);
  logic [IDX_W-1:0] lowest_free;
  logic [IDX_W-1:0] rr_pick;

  always_comb begin
    lowest_free = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (!line_vld[i]) lowest_free = IDX_W'(i);
  end

  always_comb begin
    if (rr_ptr == mru_idx)
      rr_pick = IDX_W'(vfc_pkg::wrap_next(32'(rr_ptr), LINES));
    else
      rr_pick = rr_ptr;
  end

  assign all_full   = &line_vld;
  assign victim_idx = all_full ? rr_pick : lowest_free;
endmodule

// File: rtl/vtag_filter_cache.sv
`timescale 1ns/1ps
module vtag_filter_cache
  import vfc_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 8,
  parameter int L1_WAYS    = 2,
  parameter int L1_BYTES   = 4096,
  localparam int LINE_BYTES = LINE_WORDS * WORD_BYTES,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int WSEL_W     = $clog2(LINE_WORDS),
  localparam int TAG_W      = ADDR_BITS - OFF_W,
  localparam int SET_W      = $clog2(L1_BYTES / (L1_WAYS * LINE_BYTES)),
  localparam int WAY_W      = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1,
  localparam int IDX_W      = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lk_valid,
  input  logic [ADDR_BITS-1:0] lk_addr,
  input  logic                 lk_spec_bad,
  output logic                 lk_hit,
  output logic [WORD_BITS-1:0] lk_data,
  input  logic                 wr_valid,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic [WORD_BYTES-1:0] wr_mask,
  input  logic [WAY_W-1:0]     wr_l1way,
  input  logic                 ev_valid,
  input  logic [SET_W-1:0]     ev_set,
  input  logic [WAY_W-1:0]     ev_way
);
  // Named internal events, brought out for the checker.
  logic [LINES-1:0]                      line_vld;
  logic [LINES-1:0][TAG_W-1:0]           line_tag;
  logic [LINES-1:0][WAY_W-1:0]           line_way;
  logic [LINES-1:0][LINE_WORDS-1:0]      line_wv;
  logic [LINES-1:0][LINE_WORDS-1:0][WORD_BITS-1:0] line_data;
  logic [LINES-1:0] lk_word_hits;
  logic [LINES-1:0] wr_tag_hits;
  logic [LINES-1:0] ev_hits;
  logic             alloc_fire;
  logic             cache_full;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] mru_idx;
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] wr_hit_idx;
  logic [IDX_W-1:0] lk_hit_idx;

  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [WSEL_W-1:0] lk_sel, wr_sel;
  assign lk_tag = lk_addr[ADDR_BITS-1:OFF_W];
  assign wr_tag = wr_addr[ADDR_BITS-1:OFF_W];
  assign lk_sel = lk_addr[OFF_W-1:BOFF_W];
  assign wr_sel = wr_addr[OFF_W-1:BOFF_W];

  vfc_match #(
    .LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W), .SET_W(SET_W),
    .WORDS(LINE_WORDS), .WSEL_W(WSEL_W)
  ) u_match (
    .line_vld    (line_vld),
    .tags        (line_tag),
    .ways        (line_way),
    .wvld        (line_wv),
    .lk_en       (lk_valid && !lk_spec_bad),
    .lk_tag      (lk_tag),
    .lk_sel      (lk_sel),
    .wr_tag      (wr_tag),
    .ev_en       (ev_valid),
    .ev_set      (ev_set),
    .ev_way      (ev_way),
    .lk_word_hits(lk_word_hits),
    .wr_tag_hits (wr_tag_hits),
    .ev_hits     (ev_hits)
  );

  vfc_victim #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
    .line_vld  (line_vld),
    .mru_idx   (mru_idx),
    .rr_ptr    (rr_ptr),
    .victim_idx(victim_idx),
    .all_full  (cache_full)
  );

  assign alloc_fire = wr_valid && !(|wr_tag_hits);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    vfc_line #(
      .TAG_W(TAG_W), .WAY_W(WAY_W), .WORDS(LINE_WORDS), .WSEL_W(WSEL_W)
    ) u_line (
      .clk      (clk),
      .rst      (rst),
      .alloc_en (alloc_fire && (victim_idx == IDX_W'(i))),
      .hit_wr_en(wr_valid && wr_tag_hits[i]),
      .evict_en (ev_hits[i]),
      .wr_tag   (wr_tag),
      .wr_way   (wr_l1way),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .wr_mask  (wr_mask),
      .line_ok  (line_vld[i]),
      .tag_o    (line_tag[i]),
      .way_o    (line_way[i]),
      .wvld_o   (line_wv[i]),
      .data_o   (line_data[i])
    );
  end

  // Read mux: hit vector is at most one-hot, so an OR tree suffices.
  always_comb begin
    lk_data = '0;
    for (int i = 0; i < LINES; i++)
      if (lk_word_hits[i]) lk_data = lk_data | line_data[i][lk_sel];
  end
  assign lk_hit = |lk_word_hits;

  always_comb begin
    wr_hit_idx = '0;
    lk_hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (wr_tag_hits[i])  wr_hit_idx = IDX_W'(i);
      if (lk_word_hits[i]) lk_hit_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mru_idx <= '0;
      rr_ptr  <= '0;
    end else begin
      if (wr_valid)
        mru_idx <= alloc_fire ? victim_idx : wr_hit_idx;
      else if (lk_hit)
        mru_idx <= lk_hit_idx;
      if (alloc_fire && cache_full)
        rr_ptr <= IDX_W'(vfc_pkg::wrap_next(32'(victim_idx), LINES));
    end
  end
endmodule

// File: rtl/vfc_checker.sv
`timescale 1ns/1ps
module vfc_checker #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_spec_bad,
  input logic             lk_hit,
  input logic [31:0]      lk_data,
  input logic [LINES-1:0] lk_word_hits,
  input logic [LINES-1:0] line_vld,
  input logic             ev_valid,
  input logic [LINES-1:0] ev_hits,
  input logic             alloc_fire,
  input logic             cache_full,
  input logic [IDX_W-1:0] victim_idx,
  input logic [IDX_W-1:0] mru_idx
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (line_vld == '0));

  a_r2_single_line_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_word_hits));

  a_r2_miss_data_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_data == 32'h0));

  a_r3_bad_spec_misses: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_spec_bad) |-> !lk_hit);

  a_r6_evict_clears: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> ((line_vld & $past(ev_hits)) == '0));

  a_r5_alloc_sets_line: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !ev_hits[victim_idx]) |=> line_vld[$past(victim_idx)]);

  a_r8_victim_not_mru: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && cache_full) |-> (victim_idx != mru_idx));
endmodule

bind vtag_filter_cache vfc_checker #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .lk_spec_bad (lk_spec_bad),
  .lk_hit      (lk_hit),
  .lk_data     (lk_data),
  .lk_word_hits(lk_word_hits),
  .line_vld    (line_vld),
  .ev_valid    (ev_valid),
  .ev_hits     (ev_hits),
  .alloc_fire  (alloc_fire),
  .cache_full  (cache_full),
  .victim_idx  (victim_idx),
  .mru_idx     (mru_idx)
);

// File: tb/sim_vtag_filter_cache.sv
`timescale 1ns/1ps
module sim_vtag_filter_cache;
  localparam int LINES = 8;
  localparam int WORDS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_spec_bad = 0;
  logic [31:0] lk_addr = 0;
  logic        lk_hit;
  logic [31:0] lk_data;
  logic        wr_valid = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic [3:0]  wr_mask = 0;
  logic        wr_l1way = 0;
  logic        ev_valid = 0;
  logic [5:0]  ev_set = 0;
  logic        ev_way = 0;

  always #5 clk = ~clk;

  vtag_filter_cache u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_spec_bad(lk_spec_bad), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_l1way(wr_l1way), .ev_valid(ev_valid),
    .ev_set(ev_set), .ev_way(ev_way)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Reference contents, built from the requirements.
  logic [26:0] m_tag [LINES];
  bit          m_lv  [LINES];
  bit          m_wv  [LINES][WORDS];
  logic [31:0] m_dat [LINES][WORDS];
  bit          m_way [LINES];
  int          m_mru, m_ptr;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [26:0] t);
    for (int i = 0; i < LINES; i++)
      if (m_lv[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < LINES; i++) begin
      m_lv[i] = 0;
      for (int w = 0; w < WORDS; w++) m_wv[i][w] = 0;
    end
    m_mru = 0;
    m_ptr = 0;
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_spec_bad = 0; wr_valid = 0; ev_valid = 0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); idle_inputs(); rst = 1;
    @(negedge clk);
    @(negedge clk); rst = 0;
    m_clear();
  endtask

  // Lookup: answer due in the same cycle, sampled 1 ns after the drive.
  task automatic lookup(input logic [31:0] a, input bit spec, input string req,
                        output bit got);
    int  idx;
    bit  eh;
    logic [31:0] ed;
    @(negedge clk); idle_inputs();
    lk_valid = 1; lk_addr = a; lk_spec_bad = spec;
    #1;
    idx = m_find(a[31:5]);
    eh  = !spec && idx >= 0 && m_wv[idx][a[4:2]];
    ed  = eh ? m_dat[idx][a[4:2]] : 32'h0;
    check(lk_hit == eh, req, {31'b0, lk_hit}, {31'b0, eh});
    check(lk_data == ed, req, lk_data, ed);
    got = lk_hit;
    if (eh) m_mru = idx;
  endtask

  // Write and/or eviction, committed at the next rising edge.
  task automatic op(input bit w, input logic [31:0] a, input logic [31:0] d,
                    input logic [3:0] m, input bit way,
                    input bit ev, input logic [5:0] s, input bit ew);
    bit evm [LINES];
    int idx, sel;
    @(negedge clk); idle_inputs();
    wr_valid = w; wr_addr = a; wr_data = d; wr_mask = m; wr_l1way = way;
    ev_valid = ev; ev_set = s; ev_way = ew;
    for (int i = 0; i < LINES; i++)
      evm[i] = ev && m_lv[i] && m_way[i] == ew && m_tag[i][5:0] == s;
    if (w) begin
      sel = a[4:2];
      idx = m_find(a[31:5]);
      if (idx < 0) begin
        bit full = 1;
        for (int i = LINES - 1; i >= 0; i--) if (!m_lv[i]) begin full = 0; idx = i; end
        if (full) begin
          idx = (m_ptr == m_mru) ? (m_ptr + 1) % LINES : m_ptr;
          m_ptr = (idx + 1) % LINES;
        end
        m_tag[idx] = a[31:5];
        m_lv[idx]  = 1;
        for (int k = 0; k < WORDS; k++) m_wv[idx][k] = 0;
      end
      m_way[idx] = way;
      if (m == 4'hF) begin
        m_dat[idx][sel] = d;
        m_wv[idx][sel]  = 1;
      end else if (m_wv[idx][sel]) begin
        for (int b = 0; b < 4; b++) if (m[b]) m_dat[idx][sel][8*b +: 8] = d[8*b +: 8];
      end
      m_mru = idx;
    end
    for (int i = 0; i < LINES; i++) if (evm[i]) m_lv[i] = 0;
  endtask

  function automatic logic [31:0] mk_addr(int hi, int set, int wd);
    return 32'h0001_0000 + 32'(hi) * 32'h1000 + 32'(set) * 32 + 32'(wd) * 4;
  endfunction

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit g;
    logic [31:0] a0, a1;
    m_clear();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state, every lookup misses
    for (int s = 0; s < 4; s++) begin
      lookup(mk_addr(0, s, s), 0, "R1 reset miss", g);
      check(g == 0, "R1 reset literal", {31'b0, g}, 32'h0);
    end

    // R5: allocate on write, single word only
    a0 = mk_addr(0, 1, 2);
    op(1, a0, 32'hA5A5_1234, 4'hF, 0, 0, 0, 0);
    lookup(a0, 0, "R5 written word hits", g);
    check(g == 1, "R5 literal hit", {31'b0, g}, 32'h1);
    lookup(mk_addr(0, 1, 3), 0, "R5 neighbour word misses", g);
    check(g == 0, "R5 no line fill", {31'b0, g}, 32'h0);

    // R4: partial merge on valid word; partial on invalid word stays invalid
    op(1, a0, 32'h00FF_EE00, 4'b0110, 0, 0, 0, 0);
    lookup(a0, 0, "R4 merged bytes", g);
    check(lk_data == 32'hA5FF_EE34, "R4 literal merge", lk_data, 32'hA5FF_EE34);
    op(1, mk_addr(0, 1, 5), 32'h1111_1111, 4'b0001, 0, 0, 0, 0);
    lookup(mk_addr(0, 1, 5), 0, "R4 partial on invalid word", g);
    check(g == 0, "R4 literal invalid kept", {31'b0, g}, 32'h0);

    // R3: wrong speculation forces miss
    lookup(a0, 1, "R3 spec bad", g);
    check(g == 0, "R3 literal miss", {31'b0, g}, 32'h0);

    // R6/R9: eviction match needs same way and set
    op(0, 0, 0, 0, 0, 1, 6'd1, 1'b1);
    lookup(a0, 0, "R9 other way keeps line", g);
    check(g == 1, "R9 literal keep", {31'b0, g}, 32'h1);
    op(0, 0, 0, 0, 0, 1, 6'd2, 1'b0);
    lookup(a0, 0, "R6 other set keeps line", g);
    check(g == 1, "R6 literal keep", {31'b0, g}, 32'h1);
    op(1, a0, 32'h0BAD_F00D, 4'hF, 1, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 6'd1, 1'b1);
    lookup(a0, 0, "R6 matching eviction", g);
    check(g == 0, "R6 literal evicted", {31'b0, g}, 32'h0);

    // R7: write and eviction on the same entry in one cycle
    a1 = mk_addr(1, 2, 0);
    op(1, a1, 32'h5555_AAAA, 4'hF, 0, 0, 0, 0);
    op(1, a1, 32'h7777_8888, 4'hF, 0, 1, 6'd2, 1'b0);
    lookup(a1, 0, "R7 eviction wins", g);
    check(g == 0, "R7 literal invalid", {31'b0, g}, 32'h0);

    // R8: fill all lines, make line 0 MRU, allocate one more
    pulse_reset();
    for (int i = 0; i < LINES; i++)
      op(1, mk_addr(i, 0, 0), 32'h100 + 32'(i), 4'hF, 0, 0, 0, 0);
    lookup(mk_addr(0, 0, 0), 0, "R8 line0 present", g);
    op(1, mk_addr(9, 0, 0), 32'h999, 4'hF, 0, 0, 0, 0);
    lookup(mk_addr(0, 0, 0), 0, "R8 MRU survives", g);
    check(g == 1, "R8 literal MRU kept", {31'b0, g}, 32'h1);
    lookup(mk_addr(1, 0, 0), 0, "R8 pointer skips MRU", g);
    check(g == 0, "R8 literal line1 replaced", {31'b0, g}, 32'h0);
    lookup(mk_addr(9, 0, 0), 0, "R8 new line hits", g);

    // R2/R8 sweep over a small address pool against the reference
    pulse_reset();
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      logic [31:0] ra = mk_addr($urandom % 3, $urandom % 4, $urandom % 8);
      logic [3:0]  rm = ($urandom % 10 < 6) ? 4'hF : 4'($urandom);
      if (r < 4)      lookup(ra, ($urandom % 8) == 0, "R2 sweep lookup", g);
      else if (r < 8) op(1, ra, $urandom, rm, 1'($urandom), 0, 0, 0);
      else if (r == 8) op(0, 0, 0, 0, 0, 1, 6'($urandom % 4), 1'($urandom));
      else            op(1, ra, $urandom, rm, 1'($urandom), 1, 6'($urandom % 4), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule